// File: doc/BRIEF.md
# Second-Order Truncating Delta-Sigma Modulator

This block turns a slowly varying unsigned K-bit code into a short signed integer stream whose running average equals the code divided by 2^M2. It is a single-loop, error-feedback modulator. Two delaying integrators are in cascade and are followed by a quantizer that only truncates. The quantizer keeps the upper bits of the second integrator. The discarded M2 low bits are the quantization error, and the loop shapes that error with a second-order high-pass response. The loop feeds back the truncated value with weight one into the first integrator and weight two into the second. The resulting transfer is Y = (U + D)·z^-2 + E·(1 - z^-1)^2. An optional one-bit dither can be added to the least significant bit of every sample to break up idle tones.

Samples enter through a valid/ready stream, and each accepted sample advances the loop by one step. Results leave through a second valid/ready stream that holds one output register. A sample is accepted only when the clock enable is high and the output register is empty or is being drained in the same cycle. Back-pressure on the output therefore stalls the input directly, and no sample is ever dropped. A plain status pin pulses when an accepted sample is above the range that keeps the integrators bounded, which is 2^K - 2^M2.

Top module: `dsm2_mod`

## Requirements
- R1: A synchronous reset (srst high at a clock edge) clears both integrators, out_valid and ovf_flag.
- R2: After reset, the first two outputs are 0. The third output is floor((u0 + d0) / 2^M2), where u0 and d0 are the first accepted sample and its dither. This is the two-sample signal delay.
- R3: Each accepted sample produces exactly one output. Call the integrator values before the update a and b. The output is v = floor(b / 2^M2), with arithmetic rounding toward minus infinity. The first integrator then becomes a + u + d - v·2^M2, and the second becomes b + a - 2·v·2^M2.
- R4: Feed a constant code u for N accepted samples after reset. The sum of the outputs, multiplied by 2^M2, is then within 3·2^M2 of (N - 2)·u.
- R5: When in_dither is 1, it adds exactly one unit to the accepted sample (for example, 127 with dither behaves as 128).
- R6: ovf_flag is high in the cycle after a sample greater than 2^K - 2^M2 is accepted (960 at defaults) and is low in every other cycle. A sample equal to the limit does not raise it.
- R7: While en is low, in_ready is low and both integrators keep their values, so the output sequence continues as if the stall had not happened.
- R8: While out_valid is high and out_ready is low, out_valid stays high, out_sample stays unchanged, and in_ready is low.
- R9: The output for an accepted sample is presented (out_valid high) in the cycle after acceptance. in_ready equals en AND (NOT out_valid OR out_ready), so the block can take one sample per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| srst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable for the loop; gates sample acceptance |
| in_valid | input | 1 | Input sample is offered |
| in_ready | output | 1 | Block can accept the offered sample |
| in_sample | input | K | Unsigned input code |
| in_dither | input | 1 | One-LSB dither added to the sample |
| out_valid | output | 1 | out_sample holds a result |
| out_ready | input | 1 | Consumer takes out_sample this cycle |
| out_sample | output | K+GUARD-M2 | Signed truncated output level |
| ovf_flag | output | 1 | One-cycle pulse: last accepted sample was above the stable limit |

## Verification
A sample accepted at clock edge P produces its result in the output register right after P. The overflow pulse is visible right after P as well. The integrator contents reach the output at the second and third accepted samples that follow. The driver forecasts each result when it sees in_ready in mid-cycle and pushes it into a queue. It checks the overflow flag just after edge P. The monitor compares results only in mid-cycle, when out_valid and out_ready are both high. For this reason, stalls from en or from back-pressure change when a comparison happens but never which value is expected.

// File: rtl/dsm2_pkg.sv
package dsm2_pkg;

  // Largest input code that keeps the loop bounded: full scale minus one output step.
  function automatic int unsigned stable_limit(int unsigned k, int unsigned m2);
    return (32'd1 << k) - (32'd1 << m2);
  endfunction

endpackage

// File: rtl/dsm2_integrator.sv
module dsm2_integrator #(
  parameter int W = 13
) (
  input  logic                clk,
  input  logic                srst,
  input  logic                step,
  input  logic signed [W-1:0] delta,
  output logic signed [W-1:0] acc
);

  // Delaying integrator: the new sum is visible one step later.
  always_ff @(posedge clk) begin
    if (srst) begin
      acc <= '0;
    end else if (step) begin
      acc <= acc + delta;
    end
  end

endmodule

// File: rtl/dsm2_trunc_quant.sv
module dsm2_trunc_quant #(
  parameter int W  = 13,
  parameter int M2 = 6,
  localparam int LW = W - M2
) (
  input  logic signed [W-1:0]  value,
  output logic signed [LW-1:0] level,
  output logic signed [W-1:0]  level_full
);

  // Dropping the low bits of a two's-complement word is a floor division.
  assign level      = value[W-1:M2];
  assign level_full = {level, {M2{1'b0}}};

endmodule

// File: rtl/dsm2_range_check.sv
module dsm2_range_check #(
  parameter int K  = 10,
  parameter int M2 = 6
) (
  input  logic [K-1:0] sample,
  output logic         above
);

  localparam int unsigned LIMIT = dsm2_pkg::stable_limit(K, M2);

  generate
    if (M2 == 0) begin : g_full_range
      // The limit equals the largest code, so nothing can exceed it.
      assign above = 1'b0;
    end else begin : g_limited
      localparam logic [K-1:0] LIMIT_K = LIMIT[K-1:0];
      assign above = (sample > LIMIT_K);
    end
  endgenerate

endmodule

// File: rtl/dsm2_out_stage.sv
module dsm2_out_stage #(
  parameter int OW = 7
) (
  input  logic                 clk,
  input  logic                 srst,
  input  logic                 load,
  input  logic signed [OW-1:0] data_in,
  input  logic                 take,
  output logic                 valid,
  output logic signed [OW-1:0] data_out
);

  always_ff @(posedge clk) begin
    if (srst) begin
      valid    <= 1'b0;
      data_out <= '0;
    end else if (load) begin
      valid    <= 1'b1;
      data_out <= data_in;
    end else if (take) begin
      valid    <= 1'b0;
    end
  end

endmodule

// File: rtl/dsm2_mod.sv
module dsm2_mod #(
  parameter int K     = 10,
  parameter int M2    = 6,
  parameter int GUARD = 3,
  localparam int W     = K + GUARD,
  localparam int OUT_W = W - M2
) (
  input  logic                    clk,
  input  logic                    srst,
  input  logic                    en,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [K-1:0]            in_sample,
  input  logic                    in_dither,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_sample,
  output logic                    ovf_flag
);

  logic                    step;
  logic                    above;
  logic signed [W-1:0]     integ1_q;
  logic signed [W-1:0]     integ2_q;
  logic signed [OUT_W-1:0] level;
  logic signed [W-1:0]     fb_full;
  logic signed [W-1:0]     sample_ext;
  logic signed [W-1:0]     dither_ext;
  logic signed [W-1:0]     delta1;
  logic signed [W-1:0]     delta2;

  // Flow control: take a sample only when the result slot is free or draining.
  assign in_ready = en && (!out_valid || out_ready);
  assign step     = in_valid && in_ready;

  assign sample_ext = $signed({{GUARD{1'b0}}, in_sample});
  assign dither_ext = $signed({{(W-1){1'b0}}, in_dither});

  // Feedback weights: one into the first stage, two into the second.
  assign delta1 = sample_ext + dither_ext - fb_full;
  assign delta2 = integ1_q - (fb_full <<< 1);

  dsm2_integrator #(.W(W)) integ1_i (
    .clk   (clk),
    .srst  (srst),
    .step  (step),
    .delta (delta1),
    .acc   (integ1_q)
  );

  dsm2_integrator #(.W(W)) integ2_i (
    .clk   (clk),
    .srst  (srst),
    .step  (step),
    .delta (delta2),
    .acc   (integ2_q)
  );

  dsm2_trunc_quant #(.W(W), .M2(M2)) quant_i (
    .value      (integ2_q),
    .level      (level),
    .level_full (fb_full)
  );

  dsm2_range_check #(.K(K), .M2(M2)) range_i (
    .sample (in_sample),
    .above  (above)
  );

  dsm2_out_stage #(.OW(OUT_W)) out_i (
    .clk      (clk),
    .srst     (srst),
    .load     (step),
    .data_in  (level),
    .take     (out_ready),
    .valid    (out_valid),
    .data_out (out_sample)
  );

  always_ff @(posedge clk) begin
    if (srst) begin
      ovf_flag <= 1'b0;
    end else begin
      ovf_flag <= step && above;
    end
  end

endmodule

// File: rtl/dsm2_mod_chk.sv
module dsm2_mod_chk #(
  parameter int K     = 10,
  parameter int M2    = 6,
  parameter int GUARD = 3,
  localparam int W     = K + GUARD,
  localparam int OUT_W = W - M2
) (
  input logic                    clk,
  input logic                    srst,
  input logic                    en,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [K-1:0]            in_sample,
  input logic                    in_dither,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [OUT_W-1:0] out_sample,
  input logic                    ovf_flag,
  input logic                    step,
  input logic signed [W-1:0]     s1,
  input logic signed [W-1:0]     s2
);

  localparam int LIMIT = int'(dsm2_pkg::stable_limit(K, M2));

  // R1: reset leaves no result and no flag behind
  a_r1_reset_clear: assert property (@(posedge clk)
    srst |=> (!out_valid && !ovf_flag));

  // R3: first stage moves by sample + dither minus the emitted level scaled up
  a_r3_first_stage: assert property (@(posedge clk) disable iff (srst)
    (in_valid && in_ready) |=>
      ($signed(s1) == $signed($past(s1)) + $signed({1'b0, $past(in_sample)})
                      + $signed({1'b0, $past(in_dither)})
                      - ($signed(out_sample) * (2 ** M2))));

  // R6: flag only after an accepted over-range sample
  a_r6_flag_cause: assert property (@(posedge clk) disable iff (srst)
    ovf_flag |-> $past(in_valid && in_ready && (int'(in_sample) > LIMIT)));

  // R6: over-range acceptance always raises the flag
  a_r6_flag_set: assert property (@(posedge clk) disable iff (srst)
    (in_valid && in_ready && (int'(in_sample) > LIMIT)) |=> ovf_flag);

  // R7: no acceptance while disabled
  a_r7_no_accept: assert property (@(posedge clk) disable iff (srst)
    !en |-> !in_ready);

  // R7: integrators frozen without a step
  a_r7_state_hold: assert property (@(posedge clk) disable iff (srst)
    !step |=> ($stable(s1) && $stable(s2)));

  // R8: a stalled result is held
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (srst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));

  // R8: a stalled result blocks the input
  a_r8_stall_block: assert property (@(posedge clk) disable iff (srst)
    (out_valid && !out_ready) |-> !in_ready);

  // R9: result present the cycle after acceptance
  a_r9_valid_next: assert property (@(posedge clk) disable iff (srst)
    (in_valid && in_ready) |=> out_valid);

endmodule

bind dsm2_mod dsm2_mod_chk #(.K(K), .M2(M2), .GUARD(GUARD)) chk_i (
  .clk        (clk),
  .srst       (srst),
  .en         (en),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_sample  (in_sample),
  .in_dither  (in_dither),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_sample (out_sample),
  .ovf_flag   (ovf_flag),
  .step       (step),
  .s1         (integ1_q),
  .s2         (integ2_q)
);

// File: tb/dsm2_mod_tb_top.sv
module dsm2_mod_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int K     = 10;
  localparam int M2    = 6;
  localparam int GUARD = 3;
  localparam int OUT_W = K + GUARD - M2;
  localparam int LIMIT = (1 << K) - (1 << M2);
  localparam int STEP  = 1 << M2;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic                    srst;
  logic                    en;
  logic                    in_valid;
  logic                    in_ready;
  logic [K-1:0]            in_sample;
  logic                    in_dither;
  logic                    out_valid;
  logic                    out_ready;
  logic signed [OUT_W-1:0] out_sample;
  logic                    ovf_flag;

  dsm2_mod #(.K(K), .M2(M2), .GUARD(GUARD)) dut_i (
    .clk        (clk),
    .srst       (srst),
    .en         (en),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_sample  (in_sample),
    .in_dither  (in_dither),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_sample (out_sample),
    .ovf_flag   (ovf_flag)
  );

  int     checks = 0;
  int     errors = 0;
  longint sb_q[$];
  longint ref_s1 = 0;
  longint ref_s2 = 0;
  longint last_out = 0;
  longint out_sum = 0;

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: a result is consumed at the edge after a mid-cycle valid && ready.
  always @(negedge clk) begin : monitor
    longint act;
    longint exp_v;
    if (!srst && out_valid && out_ready) begin
      act = longint'(out_sample);
      if (sb_q.size() == 0) begin
        check(1'b0, "R9 output without accepted sample", act, 0);
      end else begin
        exp_v = sb_q.pop_front();
        check(act == exp_v, "R3 output value (R7 continuity)", act, exp_v);
      end
      last_out = act;
      out_sum  = out_sum + act;
    end
  end

  task automatic do_reset();
    @(posedge clk); #1;
    srst = 1'b1;
    in_valid = 1'b0;
    sb_q.delete();
    ref_s1 = 0;
    ref_s2 = 0;
    repeat (2) @(posedge clk);
    #1;
    srst = 1'b0;
  endtask

  // Driver: offer a sample, forecast the result when it is about to be accepted.
  task automatic send(int u, bit d);
    longint v;
    longint fb;
    bit     over;
    in_valid  = 1'b1;
    in_sample = u[K-1:0];
    in_dither = d;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    v  = ref_s2 >>> M2;
    fb = v * STEP;
    sb_q.push_back(v);
    ref_s2 = ref_s2 + ref_s1 - 2 * fb;
    ref_s1 = ref_s1 + u + d - fb;
    over = (u > LIMIT);
    @(posedge clk); #1;
    in_valid = 1'b0;
    check(ovf_flag == over, "R6 flag after accept", longint'(ovf_flag), longint'(over));
  endtask

  task automatic send_get(int u, bit d, output longint v);
    send(u, d);
    @(posedge clk); #1;
    v = last_out;
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(posedge clk);
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stimulus
    longint      v;
    longint      held;
    int unsigned lcg;
    srst      = 1'b1;
    en        = 1'b1;
    in_valid  = 1'b0;
    in_sample = '0;
    in_dither = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    srst = 1'b0;

    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    check(ovf_flag == 1'b0, "R1 ovf_flag after reset", longint'(ovf_flag), 0);
    check(in_ready == 1'b1, "R9 in_ready idle", longint'(in_ready), 1);

    // R2: two-sample signal delay
    send_get(100, 1'b0, v);
    check(v == 0, "R2 first output", v, 0);
    send_get(200, 1'b0, v);
    check(v == 0, "R2 second output", v, 0);
    send_get(300, 1'b0, v);
    check(v == 1, "R2 third output", v, 1);

    // R8 / R9: back-pressure holds the result and blocks input
    out_ready = 1'b0;
    send(500, 1'b0);
    check(out_valid == 1'b1, "R9 valid after accept", longint'(out_valid), 1);
    held = sb_q[0];
    in_valid  = 1'b1;
    in_sample = 10'd40;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R8 valid held", longint'(out_valid), 1);
      check(longint'(out_sample) == held, "R8 sample held", longint'(out_sample), held);
      check(in_ready == 1'b0, "R8 input blocked", longint'(in_ready), 0);
    end
    in_valid  = 1'b0;
    @(posedge clk); #1;
    out_ready = 1'b1;
    send(40, 1'b0);

    // R7: enable low freezes the loop
    @(posedge clk); #1;
    en       = 1'b0;
    in_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R7 in_ready while disabled", longint'(in_ready), 0);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    en = 1'b1;
    for (int i = 0; i < 6; i++) send(700 - 50 * i, 1'b0);
    drain();

    // R5: dither adds one unit
    do_reset();
    send_get(127, 1'b1, v);
    send_get(0, 1'b0, v);
    send_get(0, 1'b0, v);
    check(v == 2, "R5 dithered 127", v, 2);
    do_reset();
    send_get(127, 1'b0, v);
    send_get(0, 1'b0, v);
    send_get(0, 1'b0, v);
    check(v == 1, "R5 plain 127", v, 1);

    // R6: range flag boundary and one-cycle pulse
    do_reset();
    send(LIMIT, 1'b0);
    send(LIMIT + 1, 1'b0);
    @(posedge clk); #1;
    check(ovf_flag == 1'b0, "R6 flag lasts one cycle", longint'(ovf_flag), 0);
    send((1 << K) - 1, 1'b1);
    drain();

    // R3: ramp and pseudo-random codes with dither
    do_reset();
    for (int i = 0; i < 40; i++) send((i * 37) % (LIMIT + 1), 1'b0);
    lcg = 32'h1234_5678;
    for (int i = 0; i < 200; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      send(int'((lcg >> 8) % (LIMIT + 1)), lcg[20]);
    end
    drain();

    // R4: average tracking for a constant code
    do_reset();
    out_sum = 0;
    for (int i = 0; i < 258; i++) send(300, 1'b0);
    drain();
    v = out_sum * STEP - longint'(256 * 300);
    if (v < 0) v = -v;
    check(v <= 3 * STEP, "R4 average error", v, 3 * STEP);

    check(sb_q.size() == 0, "R9 all results delivered", longint'(sb_q.size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule